// File: doc/BRIEF.md
# Timer Capture/Compare Channel Pair

The block holds a free-running up-counter and two registers beside it. Each register works either as a compare register or as a capture register. In compare mode a register gives a one-cycle pulse when the counter reaches its value. In capture mode it latches the counter when its trigger fires and raises a sticky flag. A three-bit mode word sets the role of each register. For the first register it also sets which trigger it listens to. Software writes the mode word only while the counter is stopped.

There are two trigger pins, A and B. Each pin passes through a digital filter that samples on the count-clock enable. A new level is accepted only after two consecutive samples agree, so a glitch shorter than two count clocks never reaches the capture logic. A two-bit edge selector per pin chooses which filtered edges count as valid.

The second register captures on the valid edge of pin A. The first register captures on one of two sources: the valid edge of pin B, or the edge of pin A opposite to A's valid edge. An input that marks the clear-on-match timer mode forces the first register into compare behaviour.

Top module: `tmr_cc_pair`

## Requirements
- R1: After a synchronous reset, the counter, the mode word, both capture flags and both match pulses are zero, so both registers start in compare mode.
- R2: The counter increases by one on each clock edge where both `run_i` and `cnt_en_i` are 1. Otherwise it holds its value. The counter can be read at address 3.
- R3: The mode word is at address 0. Bit 0 = first register captures, bit 1 = first register uses the opposite edge of pin A, bit 2 = second register captures. Bits 15..3 always read as zero. A write to address 0 while `run_i` is 1 is ignored.
- R4: A register in compare mode raises its `match_o` bit for exactly one cycle. The pulse follows the counting edge that makes the counter equal to the register's value.
- R5: A trigger level that is held for only one count-clock sample causes no capture. A level is accepted after two consecutive enable samples agree.
- R6: With mode bits 0 = 1 and 1 = 0, the first register loads the counter on the valid edge of pin B and sets `cap_flag_o[0]`. Edges on pin A have no effect on it.
- R7: With mode bits 0 = 1 and 1 = 1, the first register captures on pin A's falling edge when A's valid edge is rising, and on the rising edge when it is falling. When A's selector is "both" or "none", the first register does not capture.
- R8: With mode bit 2 = 1, the second register loads the counter on the valid edge of pin A and sets `cap_flag_o[1]`.
- R9: While `restart_mode_i` is 1, the first register never captures. It acts as a compare register and produces match pulses.
- R10: A capture flag stays set until its register is read. A read at address 1 or 2 returns the register value one cycle later and clears that flag.
- R11: Edge selector encoding per pin: 0 = none, 1 = rising, 2 = falling, 3 = both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cnt_en_i | input | 1 | Count-clock enable, also the filter sample strobe |
| run_i | input | 1 | Counter run bit; also locks the mode word |
| restart_mode_i | input | 1 | Clear-on-match mode is active; forbids capture on the first register |
| trig_a_i | input | 1 | Trigger pin A (synchronous to clk) |
| trig_b_i | input | 1 | Trigger pin B (synchronous to clk) |
| edge_a_i | input | 2 | Valid-edge selector for pin A |
| edge_b_i | input | 2 | Valid-edge selector for pin B |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 2 | 0 mode word, 1 first register, 2 second register, 3 counter |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, valid the cycle after `rd_en_i` |
| match_o | output | 2 | Compare-match pulses, bit n for register n |
| cap_flag_o | output | 2 | Sticky capture flags, bit n for register n |

## Verification
The counter is stepped one tick at a time past two different compare values. This shows that each match pulse lands on its own count and lasts one cycle. Trigger pins receive a one-sample glitch and then a two-sample level, which separates rejected noise from an accepted edge. The first register is driven under both source selections, and pin A under rising, falling and both selectors. This shows which source and which edge polarity each setting actually uses. Captures taken at different frozen counter values show that the latched value is the counter, while the restart-mode and none-selector patterns show that a capture can be suppressed.

// File: rtl/tmr_cc_pkg.sv
package tmr_cc_pkg;

    localparam int unsigned CNT_W  = 16;
    localparam int unsigned ADDR_W = 2;
    localparam int unsigned N_SLOT = 2;
    localparam int unsigned N_PIN  = 2;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_FALL = 2'd2,
        EDGE_ANY  = 2'd3
    } edge_sel_e;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL  = 2'd0,
        A_SLOT0 = 2'd1,
        A_SLOT1 = 2'd2,
        A_COUNT = 2'd3
    } reg_addr_e;

    // mode word: bit order is decoded by software
    typedef struct packed {
        logic slot1_cap;
        logic slot0_inv_a;
        logic slot0_cap;
    } ctrl_t;

    localparam int unsigned CTRL_W = $bits(ctrl_t);

    typedef struct packed {
        logic rise;
        logic fall;
    } edges_t;

    function automatic logic pick_edge(edge_sel_e sel, edges_t e);
        case (sel)
            EDGE_RISE: return e.rise;
            EDGE_FALL: return e.fall;
            EDGE_ANY:  return e.rise | e.fall;
            default:   return 1'b0;
        endcase
    endfunction

    function automatic logic pick_opposite(edge_sel_e sel, edges_t e);
        case (sel)
            EDGE_RISE: return e.fall;
            EDGE_FALL: return e.rise;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/tmr_cc_filter.sv
module tmr_cc_filter (
    input  logic                clk,
    input  logic                rst,
    input  logic                sample,
    input  logic                pin,
    output tmr_cc_pkg::edges_t  edges
);
    logic smp_q;
    logic lvl_q;
    logic lvl_d_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            smp_q   <= 1'b0;
            lvl_q   <= 1'b0;
            lvl_d_q <= 1'b0;
        end else begin
            lvl_d_q <= lvl_q;
            if (sample) begin
                smp_q <= pin;
                if (pin == smp_q) begin
                    lvl_q <= pin;
                end
            end
        end
    end

    assign edges.rise = lvl_q & ~lvl_d_q;
    assign edges.fall = ~lvl_q & lvl_d_q;

endmodule

// File: rtl/tmr_cc_slot.sv
module tmr_cc_slot #(
    parameter int unsigned W = tmr_cc_pkg::CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] cnt_inc,
    input  logic         cap_mode,
    input  logic         cap_trig,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         clr_flag,
    output logic [W-1:0] val,
    output logic         flag,
    output logic         match
);
    logic take;

    assign take = cap_mode & cap_trig;

    always_ff @(posedge clk) begin
        if (rst) begin
            val   <= '0;
            flag  <= 1'b0;
            match <= 1'b0;
        end else begin
            match <= !cap_mode && tick && (cnt_inc == val);
            if (take) begin
                val <= cnt;
            end else if (wr) begin
                val <= wdata;
            end
            if (take) begin
                flag <= 1'b1;
            end else if (clr_flag) begin
                flag <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/tmr_cc_pair.sv
module tmr_cc_pair #(
    parameter int unsigned CNT_W  = tmr_cc_pkg::CNT_W,
    parameter int unsigned ADDR_W = tmr_cc_pkg::ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cnt_en_i,
    input  logic              run_i,
    input  logic              restart_mode_i,
    input  logic              trig_a_i,
    input  logic              trig_b_i,
    input  logic [1:0]        edge_a_i,
    input  logic [1:0]        edge_b_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [CNT_W-1:0]  wdata_i,
    output logic [CNT_W-1:0]  rdata_o,
    output logic [1:0]        match_o,
    output logic [1:0]        cap_flag_o
);
    import tmr_cc_pkg::*;

    localparam int unsigned NS = N_SLOT;
    localparam int unsigned NP = N_PIN;

    logic             tick;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_inc;
    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] rdata_q;

    assign tick    = run_i & cnt_en_i;
    assign cnt_inc = cnt_q + CNT_W'(1);

    // counter
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_inc;
        end
    end

    // mode word, locked while running
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr_en_i && !run_i && addr_i == ADDR_W'(A_CTRL)) begin
            ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
        end
    end

    // trigger filters: index 0 = pin A, 1 = pin B
    logic [NP-1:0] pin_vec;
    edges_t        pin_edges [NP];

    assign pin_vec = {trig_b_i, trig_a_i};

    for (genvar p = 0; p < NP; p++) begin : g_pin
        tmr_cc_filter i_filter (
            .clk    (clk),
            .rst    (rst),
            .sample (cnt_en_i),
            .pin    (pin_vec[p]),
            .edges  (pin_edges[p])
        );
    end

    // trigger routing
    edge_sel_e     sel_a;
    edge_sel_e     sel_b;
    logic [NS-1:0] cap_mode;
    logic [NS-1:0] cap_trig;

    assign sel_a = edge_sel_e'(edge_a_i);
    assign sel_b = edge_sel_e'(edge_b_i);

    assign cap_mode[0] = ctrl_q.slot0_cap & ~restart_mode_i;
    assign cap_mode[1] = ctrl_q.slot1_cap;

    assign cap_trig[0] = ctrl_q.slot0_inv_a ? pick_opposite(sel_a, pin_edges[0])
                                            : pick_edge(sel_b, pin_edges[1]);
    assign cap_trig[1] = pick_edge(sel_a, pin_edges[0]);

    // register slots at addresses 1 and 2
    logic [CNT_W-1:0] slot_val [NS];

    for (genvar g = 0; g < NS; g++) begin : g_slot
        logic sel_here;
        assign sel_here = (addr_i == ADDR_W'(g + 1));

        tmr_cc_slot #(.W(CNT_W)) i_slot (
            .clk      (clk),
            .rst      (rst),
            .tick     (tick),
            .cnt      (cnt_q),
            .cnt_inc  (cnt_inc),
            .cap_mode (cap_mode[g]),
            .cap_trig (cap_trig[g]),
            .wr       (wr_en_i & sel_here),
            .wdata    (wdata_i),
            .clr_flag (rd_en_i & sel_here),
            .val      (slot_val[g]),
            .flag     (cap_flag_o[g]),
            .match    (match_o[g])
        );
    end

    // registered read port
    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (rd_en_i) begin
            case (reg_addr_e'(addr_i))
                A_CTRL:  rdata_q <= CNT_W'(ctrl_q);
                A_SLOT0: rdata_q <= slot_val[0];
                A_SLOT1: rdata_q <= slot_val[1];
                default: rdata_q <= cnt_q;
            endcase
        end
    end

    assign rdata_o = rdata_q;

endmodule

// File: rtl/tmr_cc_chk.sv
module tmr_cc_chk #(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned ADDR_W = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              cnt_en_i,
    input logic              run_i,
    input logic              restart_mode_i,
    input logic              wr_en_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [2:0]        ctrl_bits,
    input logic [CNT_W-1:0]  cnt,
    input logic [1:0]        match,
    input logic [1:0]        flag
);
    logic past_ok;

    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (cnt == '0 && flag == 2'b00 && match == 2'b00 && ctrl_bits == 3'b000));

    // R2
    count_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !$past(run_i && cnt_en_i)) |-> $stable(cnt));

    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(run_i && cnt_en_i)) |-> (cnt == CNT_W'($past(cnt) + CNT_W'(1))));

    // R3
    ctrl_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (run_i && wr_en_i && addr_i == '0) |=> $stable(ctrl_bits));

    // R4
    match_tick_chk: assert property (@(posedge clk) disable iff (rst)
        (past_ok && match != 2'b00) |-> $past(run_i && cnt_en_i));

    // R9
    restart_nocap_chk: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $rose(flag[0])) |-> !$past(restart_mode_i));

    // R8
    slot1_mode_chk: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $rose(flag[1])) |-> $past(ctrl_bits[2]));

endmodule

bind tmr_cc_pair tmr_cc_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) i_chk (
    .clk            (clk),
    .rst            (rst),
    .cnt_en_i       (cnt_en_i),
    .run_i          (run_i),
    .restart_mode_i (restart_mode_i),
    .wr_en_i        (wr_en_i),
    .addr_i         (addr_i),
    .ctrl_bits      (ctrl_q),
    .cnt            (cnt_q),
    .match          (match_o),
    .flag           (cap_flag_o)
);

// File: tb/test_tmr_cc_pair.sv
`timescale 1ns/1ps
module test_tmr_cc_pair;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cnt_en = 1'b0;
    logic        run = 1'b0;
    logic        restart = 1'b0;
    logic        trig_a = 1'b0;
    logic        trig_b = 1'b0;
    logic [1:0]  edge_a = 2'd0;
    logic [1:0]  edge_b = 2'd0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [15:0] wdata = 16'h0;
    logic [15:0] rdata;
    logic [1:0]  match;
    logic [1:0]  flag;

    always #5 clk = ~clk;

    tmr_cc_pair i_tmr_cc_pair (
        .clk            (clk),
        .rst            (rst),
        .cnt_en_i       (cnt_en),
        .run_i          (run),
        .restart_mode_i (restart),
        .trig_a_i       (trig_a),
        .trig_b_i       (trig_b),
        .edge_a_i       (edge_a),
        .edge_b_i       (edge_b),
        .wr_en_i        (wr_en),
        .rd_en_i        (rd_en),
        .addr_i         (addr),
        .wdata_i        (wdata),
        .rdata_o        (rdata),
        .match_o        (match),
        .cap_flag_o     (flag)
    );

    // observed signal codes
    localparam int S_RD = 0, S_M0 = 1, S_M1 = 2, S_F0 = 3, S_F1 = 4;

    typedef struct {
        int          cyc;
        int          sig;
        logic [15:0] val;
        string       tag;
    } exp_t;

    exp_t sb_q[$];
    int   ncyc = 0;
    int   vectors = 0;
    int   misses = 0;
    bit   done = 1'b0;

    always @(posedge clk) ncyc <= ncyc + 1;

    function automatic logic [15:0] obs(int sig);
        case (sig)
            S_RD:    return rdata;
            S_M0:    return {15'd0, match[0]};
            S_M1:    return {15'd0, match[1]};
            S_F0:    return {15'd0, flag[0]};
            default: return {15'd0, flag[1]};
        endcase
    endfunction

    // monitor: pop and compare items due this cycle
    always @(negedge clk) begin
        for (int i = sb_q.size() - 1; i >= 0; i--) begin
            if (sb_q[i].cyc == ncyc) begin
                vectors++;
                if (obs(sb_q[i].sig) !== sb_q[i].val) begin
                    misses++;
                    $display("FAIL %s sig=%0d actual=%h expected=%h",
                             sb_q[i].tag, sb_q[i].sig, obs(sb_q[i].sig), sb_q[i].val);
                end
                sb_q.delete(i);
            end
        end
    end

    task automatic expect_next(int sig, logic [15:0] v, string tag);
        sb_q.push_back('{ncyc + 1, sig, v, tag});
    endtask

    task automatic chk_now(int sig, logic [15:0] v, string tag);
        @(negedge clk);
        expect_next(sig, v, tag);
    endtask

    task automatic wr(logic [1:0] a, logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, logic [15:0] e, string tag);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        expect_next(S_RD, e, tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic run_ticks(int n);
        @(negedge clk);
        run = 1'b1;
        repeat (n) begin
            cnt_en = 1'b1;
            @(negedge clk);
        end
        cnt_en = 1'b0;
        run = 1'b0;
    endtask

    task automatic tick_chk(logic m0, logic m1, string tag);
        @(negedge clk);
        run = 1'b1; cnt_en = 1'b1;
        expect_next(S_M0, {15'd0, m0}, tag);
        expect_next(S_M1, {15'd0, m1}, tag);
        @(negedge clk);
        cnt_en = 1'b0; run = 1'b0;
    endtask

    // pin 0 = A, 1 = B; hold level across n enable samples, counter frozen
    task automatic pin_hold(int which, logic lvl, int n);
        @(negedge clk);
        if (which == 0) trig_a = lvl; else trig_b = lvl;
        repeat (n) begin
            cnt_en = 1'b1;
            @(negedge clk);
        end
        cnt_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(2'd0, 16'h0000, "R1 mode word");
        rd(2'd3, 16'h0000, "R1 counter");
        chk_now(S_F0, 0, "R1 flag0");
        chk_now(S_F1, 0, "R1 flag1");
        chk_now(S_M0, 0, "R1 match0");

        // R3 reserved bits and run lock
        wr(2'd0, 16'hFFFF);
        rd(2'd0, 16'h0007, "R3 reserved bits read zero");
        @(negedge clk); run = 1'b1;
        wr(2'd0, 16'h0000);
        run = 1'b0;
        rd(2'd0, 16'h0007, "R3 write ignored while running");
        wr(2'd0, 16'h0000);
        rd(2'd0, 16'h0000, "R3 write accepted when stopped");

        // R4 compare pulses, R2 counting
        wr(2'd1, 16'd5);
        wr(2'd2, 16'd8);
        for (int i = 1; i <= 10; i++) begin
            tick_chk(i == 5, i == 8, "R4 compare pulse");
        end
        rd(2'd3, 16'd10, "R2 count after ten ticks");
        @(negedge clk); cnt_en = 1'b1;
        repeat (3) @(negedge clk);
        cnt_en = 1'b0;
        rd(2'd3, 16'd10, "R2 hold when run low");

        // R6 first register on pin B, R5 glitch rejection
        wr(2'd0, 16'h0001);
        edge_a = 2'd1; edge_b = 2'd1;
        pin_hold(0, 1'b1, 2);
        chk_now(S_F0, 0, "R6 pin A ignored");
        pin_hold(0, 1'b0, 2);
        pin_hold(1, 1'b1, 1);
        pin_hold(1, 1'b0, 2);
        chk_now(S_F0, 0, "R5 one-sample glitch");
        pin_hold(1, 1'b1, 2);
        chk_now(S_F0, 1, "R6 capture on B rise");
        repeat (4) @(negedge clk);
        chk_now(S_F0, 1, "R10 flag sticky");
        rd(2'd1, 16'd10, "R6 captured value");
        chk_now(S_F0, 0, "R10 flag cleared by read");
        pin_hold(1, 1'b0, 2);
        chk_now(S_F0, 0, "R11 fall ignored for rising select");

        // R7 opposite edge of pin A
        run_ticks(7);
        wr(2'd0, 16'h0003);
        edge_a = 2'd1;
        pin_hold(0, 1'b1, 2);
        chk_now(S_F0, 0, "R7 valid edge not used");
        pin_hold(0, 1'b0, 2);
        chk_now(S_F0, 1, "R7 opposite edge captures");
        rd(2'd1, 16'd17, "R7 captured value");
        edge_a = 2'd3;
        pin_hold(0, 1'b1, 2);
        pin_hold(0, 1'b0, 2);
        chk_now(S_F0, 0, "R7 both-edge select gives no capture");

        // R8 second register on pin A
        wr(2'd0, 16'h0004);
        edge_a = 2'd2;
        run_ticks(3);
        pin_hold(0, 1'b1, 2);
        chk_now(S_F1, 0, "R8 rise ignored for falling select");
        pin_hold(0, 1'b0, 2);
        chk_now(S_F1, 1, "R8 capture on A fall");
        rd(2'd2, 16'd20, "R8 captured value");
        chk_now(S_F1, 0, "R10 flag1 cleared by read");

        // R9 restart mode forces compare
        restart = 1'b1;
        wr(2'd0, 16'h0001);
        edge_b = 2'd1;
        pin_hold(1, 1'b1, 2);
        chk_now(S_F0, 0, "R9 no capture in restart mode");
        wr(2'd1, 16'd23);
        tick_chk(1'b0, 1'b0, "R9 compare forced");
        tick_chk(1'b0, 1'b0, "R9 compare forced");
        tick_chk(1'b1, 1'b0, "R9 compare forced");
        restart = 1'b0;

        // R11 encodings none and falling
        edge_b = 2'd0;
        pin_hold(1, 1'b0, 2);
        pin_hold(1, 1'b1, 2);
        chk_now(S_F0, 0, "R11 none select");
        edge_b = 2'd2;
        pin_hold(1, 1'b0, 2);
        chk_now(S_F0, 1, "R11 falling select");
        rd(2'd1, 16'd23, "R11 captured value");

        repeat (3) @(negedge clk);
        if (sb_q.size() != 0) begin
            misses++;
            $display("FAIL pending expectations actual=%0d expected=0", sb_q.size());
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            misses++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

endmodule